// File: doc/BRIEF.md
# Floating-Point Register Stack Control Unit

This block keeps the bookkeeping state of an eight-entry floating-point register stack. The state is a top-of-stack pointer, one empty flag per physical entry, a 16-bit status word and a 16-bit control word. The block holds no register data. An execution sequencer drives one-cycle command strobes. The commands are push, pop, pointer step up, pointer step down, release entry, full initialise, exception clear, exception raise, control load and comparison outcome. The block updates its state on the next clock edge.

The status word is read with the live top pointer inserted in bits 13:11. Raising an exception that the control word leaves unmasked also sets an error summary flag and a busy flag. A wait query turns that summary flag into an error request that the surrounding core can act on. Only one command takes effect per clock, chosen by a fixed priority. Reset leaves the block in the same state as the initialise command.

Top module: `fpstack_ctl`

## Requirements
- R1: After reset, and one cycle after an accepted initialise, the read status word is 0x0000, the control word is 0x037F, the top pointer is 0 and all eight empty flags are 1.
- R2: An accepted push lowers the top pointer by one modulo 8 and clears the empty flag of the entry that becomes the new top.
- R3: An accepted pop sets the empty flag of the entry at the current top and then raises the top pointer by one modulo 8.
- R4: The read status word equals the stored status with bits 13:11 replaced by the 3-bit top pointer.
- R5: An accepted raise ORs the 6-bit flag input into status bits 5:0. If any raised flag has a 0 in the matching bit of control word bits 5:0, status bits 7 (error summary) and 15 (busy) are also set. Otherwise bits 7 and 15 keep their value.
- R6: An accepted exception clear keeps only status bits 14:8 and zeroes the others.
- R7: An accepted step up or step down changes the top pointer by +1 or -1 modulo 8. It leaves every empty flag unchanged and clears status bits 14, 10, 9 and 8 (mask 0x4700).
- R8: An accepted compare writes status bits 14, 10 and 8 (mask 0x4500) from the 2-bit relation code and keeps all other status bits. The codes are 00 less → 0x0100, 01 equal → 0x4000, 10 greater → 0x0000 and 11 unordered → 0x4500.
- R9: An accepted release with index N sets the empty flag of physical entry (top + N) mod 8. The pointer does not change.
- R10: The error request output is high in the same cycle that the wait strobe is high and status bit 7 is set. It is low otherwise. The wait strobe changes no state.
- R11: When several strobes are high at once, only one is accepted. The priority from highest to lowest is initialise, push, pop, step up, step down, release, exception clear, raise, control load, compare.
- R12: An accepted control load writes the full 16-bit control word. Its bits 5:0 then act as the masks for R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as initialise |
| cmd_init | input | 1 | Initialise strobe |
| cmd_push | input | 1 | Push strobe |
| cmd_pop | input | 1 | Pop strobe |
| cmd_inc | input | 1 | Step top pointer up |
| cmd_dec | input | 1 | Step top pointer down |
| cmd_free | input | 1 | Release entry strobe |
| free_sel | input | 3 | Entry offset N, relative to top, for release |
| cmd_clr_exc | input | 1 | Exception clear strobe |
| cmd_raise | input | 1 | Exception raise strobe |
| exc_flags | input | 6 | Exception flags to raise |
| cmd_ld_ctrl | input | 1 | Control word load strobe |
| ctrl_in | input | 16 | New control word |
| cmd_cmp | input | 1 | Compare outcome strobe |
| cmp_rel | input | 2 | Relation code for compare |
| cmd_wait | input | 1 | Wait query |
| stat_word | output | 16 | Assembled status word |
| ctrl_word | output | 16 | Current control word |
| tag_empty | output | 8 | Empty flag per physical entry |
| top_ptr | output | 3 | Top-of-stack pointer |
| err_req | output | 1 | Pending error request |

## Verification
A wrong pointer shows at once in two places: top_ptr and bits 13:11 of stat_word, both one clock after the command. A wrong empty flag shows in tag_empty in that same cycle. A misplaced flag can also be read back through a later pop, push or release, because those depend on where the pointer sits. A lost or spurious error summary shows on err_req as soon as a wait is issued. The bench therefore checks the full visible state after each command. It also checks priority collisions, where a wrongly accepted command leaves changes in the pointer, the flags or the condition bits.

// File: rtl/fpstack_pkg.sv
package fpstack_pkg;

   localparam int OP_W     = 4;
   localparam int N_OPS    = 10;
   localparam int EXC_W    = 6;
   localparam int SW_W     = 16;
   localparam int TOP_LSB  = 11;
   localparam int TOP_W    = 3;
   localparam int SUM_BIT  = 7;
   localparam int BUSY_BIT = 15;

   localparam logic [SW_W-1:0] KEEP_ON_CLR  = 16'h7F00;
   localparam logic [SW_W-1:0] COND_ALL     = 16'h4700;
   localparam logic [SW_W-1:0] COND_CMP     = 16'h4500;
   localparam logic [SW_W-1:0] TOP_FIELD    = 16'h3800;

   // Encoding order equals priority order: a lower value wins.
   typedef enum logic [OP_W-1:0] {
      OP_NONE  = 4'd0,
      OP_INIT  = 4'd1,
      OP_PUSH  = 4'd2,
      OP_POP   = 4'd3,
      OP_INCP  = 4'd4,
      OP_DECP  = 4'd5,
      OP_FREE  = 4'd6,
      OP_CLRX  = 4'd7,
      OP_RAISE = 4'd8,
      OP_WRCW  = 4'd9,
      OP_CMP   = 4'd10
   } op_e;

   function automatic logic [SW_W-1:0] cmp_code(input logic [1:0] rel);
      logic [SW_W-1:0] c;
      unique case (rel)
         2'b00:   c = 16'h0100;
         2'b01:   c = 16'h4000;
         2'b10:   c = 16'h0000;
         default: c = 16'h4500;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/fpstack_arb.sv
module fpstack_arb
   import fpstack_pkg::*;
#(
   parameter int NREQ = N_OPS
) (
   input  logic [NREQ-1:0] req,
   output op_e             sel
);

   if (NREQ != N_OPS) begin : g_bad_nreq
      $error("fpstack_arb: NREQ must match the command set");
   end

   // req[0] has the highest priority; scanning downward lets it win.
   always_comb begin
      sel = OP_NONE;
      for (int i = NREQ - 1; i >= 0; i--) begin
         if (req[i]) sel = op_e'(OP_W'(i + 1));
      end
   end

endmodule

// File: rtl/fpstack_ptr_tags.sv
module fpstack_ptr_tags
   import fpstack_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              sel,
   input  logic [PTR_W-1:0] free_sel,
   output logic [PTR_W-1:0] ptr_q,
   output logic [DEPTH-1:0] tags_q
);

   logic [PTR_W-1:0] ptr_dn;
   logic [PTR_W-1:0] ptr_up;
   logic [PTR_W-1:0] free_pos;

   assign ptr_dn   = ptr_q - PTR_W'(1);
   assign ptr_up   = ptr_q + PTR_W'(1);
   assign free_pos = ptr_q + free_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         unique case (sel)
            OP_INIT:          ptr_q <= '0;
            OP_PUSH, OP_DECP: ptr_q <= ptr_dn;
            OP_POP,  OP_INCP: ptr_q <= ptr_up;
            default:          ptr_q <= ptr_q;
         endcase
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_tag
      logic hit_new, hit_old, hit_free;
      assign hit_new  = (ptr_dn   == PTR_W'(g));
      assign hit_old  = (ptr_q    == PTR_W'(g));
      assign hit_free = (free_pos == PTR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tags_q[g] <= 1'b1;
         end else begin
            unique case (sel)
               OP_INIT: tags_q[g] <= 1'b1;
               OP_PUSH: if (hit_new)  tags_q[g] <= 1'b0;
               OP_POP:  if (hit_old)  tags_q[g] <= 1'b1;
               OP_FREE: if (hit_free) tags_q[g] <= 1'b1;
               default: tags_q[g] <= tags_q[g];
            endcase
         end
      end
   end

   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_INIT) |=> (ptr_q == '0) && (&tags_q)); // R1
   AST_PUSH_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_PUSH) |=> (ptr_q == $past(ptr_q) - PTR_W'(1)) && !tags_q[ptr_q]); // R2
   AST_POP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_POP) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)) && tags_q[$past(ptr_q)]); // R3
   AST_STEP_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_INCP || sel == OP_DECP) |=> $stable(tags_q)); // R7
   AST_FREE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_FREE) |=> tags_q[$past(free_pos)] && $stable(ptr_q)); // R9

endmodule

// File: rtl/fpstack_status.sv
module fpstack_status
   import fpstack_pkg::*;
#(
   parameter logic [SW_W-1:0] INIT_CW = 16'h037F,
   parameter int              PTR_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              sel,
   input  logic [EXC_W-1:0] exc_flags,
   input  logic [SW_W-1:0]  ctrl_in,
   input  logic [1:0]       cmp_rel,
   input  logic             cmd_wait,
   input  logic [PTR_W-1:0] ptr,
   output logic [SW_W-1:0]  stat_word,
   output logic [SW_W-1:0]  ctrl_word,
   output logic             err_req
);

   if (PTR_W > TOP_W) begin : g_bad_ptr
      $error("fpstack_status: pointer does not fit the status field");
   end

   logic [SW_W-1:0] st_q;
   logic [SW_W-1:0] cw_q;
   logic            unmasked;
   logic [SW_W-1:0] raise_bits;

   assign unmasked   = |(exc_flags & ~cw_q[EXC_W-1:0]);
   assign raise_bits = SW_W'(exc_flags)
                     | (unmasked ? ((SW_W'(1) << SUM_BIT) | (SW_W'(1) << BUSY_BIT)) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
         cw_q <= INIT_CW;
      end else begin
         unique case (sel)
            OP_INIT: begin
               st_q <= '0;
               cw_q <= INIT_CW;
            end
            OP_INCP, OP_DECP: st_q <= st_q & ~COND_ALL;
            OP_CLRX:          st_q <= st_q & KEEP_ON_CLR;
            OP_RAISE:         st_q <= st_q | raise_bits;
            OP_WRCW:          cw_q <= ctrl_in;
            OP_CMP:           st_q <= (st_q & ~COND_CMP) | cmp_code(cmp_rel);
            default:          st_q <= st_q;
         endcase
      end
   end

   assign stat_word = (st_q & ~TOP_FIELD) | (SW_W'(ptr) << TOP_LSB);
   assign ctrl_word = cw_q;
   assign err_req   = cmd_wait & st_q[SUM_BIT];

   AST_CLRX_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_CLRX) |=> ((st_q & ~KEEP_ON_CLR) == '0)
                           && ((st_q & KEEP_ON_CLR) == ($past(st_q) & KEEP_ON_CLR))); // R6
   AST_RAISE_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_RAISE && unmasked) |=> st_q[SUM_BIT] && st_q[BUSY_BIT]); // R5
   AST_RAISE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_RAISE && !unmasked) |=> $stable(st_q[SUM_BIT]) && $stable(st_q[BUSY_BIT])); // R5
   AST_CMP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_CMP) |=> ((st_q & ~COND_CMP) == ($past(st_q) & ~COND_CMP))); // R8
   AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_INCP || sel == OP_DECP) |=> ((st_q & COND_ALL) == '0)); // R7
   AST_CW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OP_WRCW) |=> (cw_q == $past(ctrl_in))); // R12
   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wait && sel == OP_NONE) |=> $stable(st_q) && $stable(cw_q)); // R10

endmodule

// File: rtl/fpstack_ctl.sv
module fpstack_ctl
   import fpstack_pkg::*;
#(
   parameter int              DEPTH   = 8,
   parameter logic [SW_W-1:0] INIT_CW = 16'h037F,
   localparam int             PTR_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_init,
   input  logic             cmd_push,
   input  logic             cmd_pop,
   input  logic             cmd_inc,
   input  logic             cmd_dec,
   input  logic             cmd_free,
   input  logic [PTR_W-1:0] free_sel,
   input  logic             cmd_clr_exc,
   input  logic             cmd_raise,
   input  logic [EXC_W-1:0] exc_flags,
   input  logic             cmd_ld_ctrl,
   input  logic [SW_W-1:0]  ctrl_in,
   input  logic             cmd_cmp,
   input  logic [1:0]       cmp_rel,
   input  logic             cmd_wait,
   output logic [SW_W-1:0]  stat_word,
   output logic [SW_W-1:0]  ctrl_word,
   output logic [DEPTH-1:0] tag_empty,
   output logic [PTR_W-1:0] top_ptr,
   output logic             err_req
);

   if (DEPTH < 2 || DEPTH > (1 << TOP_W) || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fpstack_ctl: DEPTH must be a power of two from 2 to 8");
   end

   logic [N_OPS-1:0] req;
   op_e              sel;

   // Bit position is priority rank, 0 highest.
   assign req = {cmd_cmp, cmd_ld_ctrl, cmd_raise, cmd_clr_exc, cmd_free,
                 cmd_dec, cmd_inc, cmd_pop, cmd_push, cmd_init};

   fpstack_arb #(.NREQ(N_OPS)) u_arb (
      .req (req),
      .sel (sel)
   );

   fpstack_ptr_tags #(.DEPTH(DEPTH)) u_ptr_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .free_sel (free_sel),
      .ptr_q    (top_ptr),
      .tags_q   (tag_empty)
   );

   fpstack_status #(.INIT_CW(INIT_CW), .PTR_W(PTR_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .exc_flags (exc_flags),
      .ctrl_in   (ctrl_in),
      .cmp_rel   (cmp_rel),
      .cmd_wait  (cmd_wait),
      .ptr       (top_ptr),
      .stat_word (stat_word),
      .ctrl_word (ctrl_word),
      .err_req   (err_req)
   );

   AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_init |-> (sel == OP_INIT)); // R11
   AST_PUSH_OVER_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_push && !cmd_init) |-> (sel == OP_PUSH)); // R11
   AST_TOP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[TOP_LSB +: TOP_W] == TOP_W'(top_ptr)); // R4

endmodule

// File: tb/fpstack_ctl_tb.sv
module fpstack_ctl_tb;

   localparam int B_INIT = 0, B_PUSH = 1, B_POP = 2, B_INC = 3, B_DEC = 4,
                  B_FREE = 5, B_CLR = 6, B_RAISE = 7, B_LDCW = 8, B_CMP = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  rq = '0;
   logic [2:0]  free_sel = '0;
   logic [5:0]  exc_flags = '0;
   logic [15:0] ctrl_in = '0;
   logic [1:0]  cmp_rel = '0;
   logic        cmd_wait = 1'b0;
   logic [15:0] stat_word, ctrl_word;
   logic [7:0]  tag_empty;
   logic [2:0]  top_ptr;
   logic        err_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // Model of the visible state, kept from the requirements.
   logic [2:0]  m_ptr;
   logic [7:0]  m_tag;
   logic [15:0] m_st;
   logic [15:0] m_cw;

   always #4 clk = ~clk;

   fpstack_ctl u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_init(rq[B_INIT]), .cmd_push(rq[B_PUSH]), .cmd_pop(rq[B_POP]),
      .cmd_inc(rq[B_INC]), .cmd_dec(rq[B_DEC]), .cmd_free(rq[B_FREE]),
      .free_sel(free_sel), .cmd_clr_exc(rq[B_CLR]), .cmd_raise(rq[B_RAISE]),
      .exc_flags(exc_flags), .cmd_ld_ctrl(rq[B_LDCW]), .ctrl_in(ctrl_in),
      .cmd_cmp(rq[B_CMP]), .cmp_rel(cmp_rel), .cmd_wait(cmd_wait),
      .stat_word(stat_word), .ctrl_word(ctrl_word), .tag_empty(tag_empty),
      .top_ptr(top_ptr), .err_req(err_req)
   );

   task automatic chk(input string rqn, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rqn, act, exp);
      end
   endtask

   task automatic model_init();
      m_ptr = 3'd0; m_tag = 8'hFF; m_st = 16'h0000; m_cw = 16'h037F;
   endtask

   function automatic logic [15:0] rel_code(input logic [1:0] r);
      case (r)
         2'b00: return 16'h0100;
         2'b01: return 16'h4000;
         2'b10: return 16'h0000;
         default: return 16'h4500;
      endcase
   endfunction

   task automatic model_apply(input logic [9:0] r, input logic [2:0] fs,
                              input logic [5:0] ef, input logic [15:0] cw,
                              input logic [1:0] cr);
      if (r[B_INIT]) model_init();                                   // R1, R11
      else if (r[B_PUSH]) begin m_ptr = m_ptr - 3'd1; m_tag[m_ptr] = 1'b0; end // R2
      else if (r[B_POP])  begin m_tag[m_ptr] = 1'b1; m_ptr = m_ptr + 3'd1; end // R3
      else if (r[B_INC])  begin m_ptr = m_ptr + 3'd1; m_st &= ~16'h4700; end   // R7
      else if (r[B_DEC])  begin m_ptr = m_ptr - 3'd1; m_st &= ~16'h4700; end   // R7
      else if (r[B_FREE]) m_tag[3'(m_ptr + fs)] = 1'b1;                        // R9
      else if (r[B_CLR])  m_st &= 16'h7F00;                                    // R6
      else if (r[B_RAISE]) begin                                               // R5
         m_st |= {10'd0, ef};
         if ((ef & ~m_cw[5:0]) != 6'd0) m_st |= 16'h8080;
      end
      else if (r[B_LDCW]) m_cw = cw;                                           // R12
      else if (r[B_CMP])  m_st = (m_st & ~16'h4500) | rel_code(cr);            // R8
   endtask

   task automatic go(input logic [9:0] r, input logic [2:0] fs = 3'd0,
                     input logic [5:0] ef = 6'd0, input logic [15:0] cw = 16'd0,
                     input logic [1:0] cr = 2'd0);
      @(negedge clk);
      rq = r; free_sel = fs; exc_flags = ef; ctrl_in = cw; cmp_rel = cr;
      model_apply(r, fs, ef, cw, cr);
      @(negedge clk);
      rq = '0; free_sel = '0; exc_flags = '0; ctrl_in = '0; cmp_rel = '0;
   endtask

   task automatic chk_model(input string rqn);
      chk({rqn, " status"}, stat_word, (m_st & ~16'h3800) | (16'(m_ptr) << 11));
      chk({rqn, " control"}, ctrl_word, m_cw);
      chk({rqn, " tags"}, {8'd0, tag_empty}, {8'd0, m_tag});
      chk({rqn, " top"}, {13'd0, top_ptr}, {13'd0, m_ptr});
   endtask

   task automatic t_reset();
      chk("R1 reset status", stat_word, 16'h0000);
      chk("R1 reset control", ctrl_word, 16'h037F);
      chk("R1 reset tags", {8'd0, tag_empty}, 16'h00FF);
      chk("R1 reset top", {13'd0, top_ptr}, 16'd0);
   endtask

   task automatic t_push_pop();
      go(10'(1 << B_PUSH));
      chk("R2 push top", {13'd0, top_ptr}, 16'd7);
      chk("R2 push tags", {8'd0, tag_empty}, 16'h007F);
      chk("R4 top in status", stat_word, 16'h3800);
      go(10'(1 << B_PUSH));
      chk("R2 second push tags", {8'd0, tag_empty}, 16'h003F);
      chk("R4 top6 in status", stat_word, 16'h3000);
      go(10'(1 << B_POP));
      chk("R3 pop tags", {8'd0, tag_empty}, 16'h007F);
      chk("R3 pop top", {13'd0, top_ptr}, 16'd7);
      go(10'(1 << B_POP));
      chk("R3 pop wrap top", {13'd0, top_ptr}, 16'd0);
      chk_model("R3");
   endtask

   task automatic t_step();
      go(10'(1 << B_CMP), .cr(2'b11));
      go(10'(1 << B_DEC));
      chk("R7 dec wrap", stat_word, 16'h3800);
      chk("R7 dec tags kept", {8'd0, tag_empty}, 16'h00FF);
      go(10'(1 << B_CMP), .cr(2'b01));
      go(10'(1 << B_INC));
      chk("R7 inc clears cond", stat_word, 16'h0000);
      chk_model("R7");
   endtask

   task automatic t_cmp();
      go(10'(1 << B_CMP), .cr(2'b00)); chk("R8 less", stat_word, 16'h0100);
      go(10'(1 << B_CMP), .cr(2'b01)); chk("R8 equal", stat_word, 16'h4000);
      go(10'(1 << B_CMP), .cr(2'b10)); chk("R8 greater", stat_word, 16'h0000);
      go(10'(1 << B_CMP), .cr(2'b11)); chk("R8 unordered", stat_word, 16'h4500);
   endtask

   task automatic t_raise_wait();
      go(10'(1 << B_INIT));
      go(10'(1 << B_RAISE), .ef(6'h04));
      chk("R5 masked raise", stat_word, 16'h0004);
      @(negedge clk); cmd_wait = 1'b1; #1;
      chk("R10 wait no error", {15'd0, err_req}, 16'd0);
      @(negedge clk); cmd_wait = 1'b0;
      chk("R10 wait changed nothing", stat_word, 16'h0004);
      go(10'(1 << B_LDCW), .cw(16'h037B));
      chk("R12 control load", ctrl_word, 16'h037B);
      go(10'(1 << B_RAISE), .ef(6'h01));
      chk("R5 masked flag no summary", stat_word, 16'h0005);
      go(10'(1 << B_RAISE), .ef(6'h04));
      chk("R5 unmasked summary busy", stat_word, 16'h8085);
      chk("R10 no wait no request", {15'd0, err_req}, 16'd0);
      @(negedge clk); cmd_wait = 1'b1; #1;
      chk("R10 wait error request", {15'd0, err_req}, 16'd1);
      @(negedge clk); cmd_wait = 1'b0;
      chk_model("R5");
   endtask

   task automatic t_clear();
      go(10'(1 << B_CMP), .cr(2'b11));
      chk("R8 cmp keeps others", stat_word, 16'hC585);
      go(10'(1 << B_CLR));
      chk("R6 clear keeps 14:8", stat_word, 16'h4500);
      chk_model("R6");
   endtask

   task automatic t_free();
      go(10'(1 << B_INIT));
      go(10'(1 << B_PUSH)); go(10'(1 << B_PUSH)); go(10'(1 << B_PUSH));
      chk("R9 setup tags", {8'd0, tag_empty}, 16'h001F);
      go(10'(1 << B_FREE), .fs(3'd2));
      chk("R9 free top+2", {8'd0, tag_empty}, 16'h009F);
      chk("R9 free keeps top", {13'd0, top_ptr}, 16'd5);
      go(10'(1 << B_FREE), .fs(3'd0));
      chk("R9 free top", {8'd0, tag_empty}, 16'h00BF);
      go(10'(1 << B_FREE), .fs(3'd4));
      chk("R9 free wraps", {8'd0, tag_empty}, 16'h00BF);
      chk_model("R9");
   endtask

   task automatic t_prio();
      go(10'((1 << B_INIT) | (1 << B_PUSH) | (1 << B_RAISE)), .ef(6'h3F));
      t_reset();
      chk_model("R11 init wins");
      go(10'((1 << B_PUSH) | (1 << B_POP)));
      chk("R11 push over pop tags", {8'd0, tag_empty}, 16'h007F);
      chk_model("R11 push over pop");
      go(10'(1 << B_CMP), .cr(2'b00));
      go(10'((1 << B_POP) | (1 << B_INC)));
      chk("R11 pop over inc keeps cond", stat_word, 16'h0100);
      chk_model("R11 pop over inc");
      go(10'((1 << B_INC) | (1 << B_DEC)));
      chk("R11 inc over dec", {13'd0, top_ptr}, 16'd1);
      go(10'((1 << B_RAISE) | (1 << B_CMP)), .ef(6'h02), .cr(2'b11));
      chk_model("R11 raise over cmp");
      go(10'((1 << B_LDCW) | (1 << B_CMP)), .cw(16'h0000), .cr(2'b01));
      chk("R11 load over cmp", ctrl_word, 16'h0000);
      chk_model("R11 load over cmp");
      go(10'((1 << B_FREE) | (1 << B_CLR)), .fs(3'd0));
      chk_model("R11 free over clear");
      go(10'(1 << B_INIT));
      t_reset();
   endtask

   initial begin
      model_init();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_push_pop();
      t_step();
      t_cmp();
      t_raise_wait();
      t_clear();
      t_free();
      t_prio();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule